// File: doc/BRIEF.md
# Flash Page Write Controller

This block programs one block of on-chip flash at a time. The CPU sets a byte pointer and loads a one-byte data latch. It then issues table-write strobes. Each strobe copies the latch into one byte of a 64-byte holding buffer, and the pointer can advance by itself after each strobe. Table writes take effect at once and never reach the flash.

Flash changes only during a long write. A long write starts when the CPU enables writes, writes the key byte 55h and then AAh, and finally sets the start bit. While the long write runs, the CPU stall output stays high. The controller walks the holding buffer in offset order and sends one program beat for each byte that is not FFh. The flash model combines each beat with the stored byte by AND, so bits can only be cleared. A block erase uses the same unlock sequence. It sends a single erase beat, and the model sets the addressed block to FFh.

An internal cycle timer sets the length of a long write. When it ends, the holding buffer returns to FFh and a one-cycle done pulse is raised. The flash side is a valid/ready stream. While a beat is offered and ready is low, the controller holds the beat unchanged and waits. If back-pressure delays the walk past the timer, the long write lasts until the walk finishes.

Top module: `fpw_ctrl`

## Requirements
- R1: A write with `cpu_sel`=4 copies the data latch (loaded by `cpu_sel`=1, low 8 bits) into the holding byte at offset `ptr_q[5:0]`. If the stored auto-increment bit (control bit 3) is 1, `ptr_q` then advances by 1, wrapping from all ones to 0. A write with `cpu_sel`=0 loads `ptr_q`.
- R2: Every holding byte reads FFh after reset and after each long write completes. A long write started with no table writes since then emits no flash beat.
- R3: A program long write visits offsets 0 to 63 in increasing order. Holding bytes equal to FFh produce no beat. Every other byte produces one beat with `fl_erase`=0, `fl_addr`={`ptr_q` bits above 5 at launch, offset} and `fl_data`=the byte. The flash stores old AND `fl_data`.
- R4: A long write starts only on a control write (`cpu_sel`=2) with bit 1 (start) and bit 0 (write enable) both 1, and only when the last two key writes (`cpu_sel`=3) were 55h then AAh.
- R5: Each of these clears the unlock progress, sets `err_q` and starts nothing: a key write out of the 55h-then-AAh order, a third key write after the pair, or a start request without write enable or without the pair. A successful launch clears `err_q`.
- R6: `stall` rises in the cycle after the launching write. It stays high for WRITE_CYCLES cycles, or longer until the last beat is accepted. In the cycle after it falls, `done` is high for exactly one cycle.
- R7: A launch with control bit 2 set is an erase. It emits one beat with `fl_erase`=1, `fl_data`=FFh and `fl_addr` set to the block base (offset 0). The flash sets all 64 bytes of that block to FFh.
- R8: While `fl_valid` is high and `fl_ready` is low, `fl_valid`, `fl_addr`, `fl_data` and `fl_erase` hold their values into the next cycle.
- R9: Every CPU write made while `stall` is high is ignored. This covers writes to the pointer, latch, control and key, and table writes.
- R10: The start bit is not retained. After any launch the unlock pair must be written again before the next start request succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_sel | input | 3 | Register select: 0 pointer, 1 latch, 2 control, 3 key, 4 table write |
| cpu_wdata | input | ADDR_W | Write data |
| ptr_q | output | ADDR_W | Current byte pointer |
| err_q | output | 1 | Sticky unlock error flag |
| stall | output | 1 | CPU stall, high during a long write |
| done | output | 1 | One-cycle pulse when a long write ends |
| fl_valid | output | 1 | Flash beat offered |
| fl_ready | input | 1 | Flash accepts the beat |
| fl_erase | output | 1 | Beat is a block erase |
| fl_addr | output | ADDR_W | Flash byte address of the beat |
| fl_data | output | 8 | Byte to program |

## Verification
The assertions assume that `fl_ready` may take any value in any cycle. They also assume that the CPU may write at any time, including while the controller stalls. No input is required to stay stable. The stimulus drives every input half a cycle away from the sampling edge. It toggles `fl_ready` at random during one full-block program and holds it high elsewhere. It also issues writes of every kind during a stall, so the ignore rule is tested against real traffic rather than assumed.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  typedef enum logic [2:0] {
    SEL_PTR   = 3'd0,
    SEL_LATCH = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_KEY   = 3'd3,
    SEL_TBLWR = 3'd4
  } fpw_sel_e;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2
  } fpw_key_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] BYTE_BLANK = 8'hFF;

  localparam int CTRL_WREN  = 0;
  localparam int CTRL_GO    = 1;
  localparam int CTRL_ERASE = 2;
  localparam int CTRL_INC   = 3;
endpackage

// File: rtl/fpw_keylock.sv
module fpw_keylock
  import fpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  input  logic       go_wr,
  input  logic       go_en,
  output logic       launch,
  output logic       err
);
  fpw_key_e st;

  assign launch = go_wr && go_en && (st == KEY_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= KEY_IDLE;
      err <= 1'b0;
    end else if (go_wr) begin
      st  <= KEY_IDLE;
      err <= !launch;
    end else if (key_wr) begin
      unique case (st)
        KEY_IDLE: begin
          if (key_val == KEY_FIRST) st <= KEY_HALF;
          else err <= 1'b1;
        end
        KEY_HALF: begin
          if (key_val == KEY_SECOND) st <= KEY_ARMED;
          else begin
            st  <= KEY_IDLE;
            err <= 1'b1;
          end
        end
        default: begin
          st  <= KEY_IDLE;
          err <= 1'b1;
        end
      endcase
    end
  end

  a_r10_relock_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (st == KEY_IDLE));
  a_r5_bad_first_key: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !go_wr && st == KEY_IDLE && key_val != KEY_FIRST) |=> err);
  a_r5_failed_start_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && !launch) |=> (err && st == KEY_IDLE));
endmodule

// File: rtl/fpw_holdbuf.sv
module fpw_holdbuf
  import fpw_pkg::*;
#(
  parameter int BLK_BYTES = 64,
  parameter int OFS_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             clr_all,
  input  logic [OFS_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0] bytes_q [BLK_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      for (int i = 0; i < BLK_BYTES; i++) bytes_q[i] <= BYTE_BLANK;
    end else if (wr_en) begin
      bytes_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = bytes_q[rd_idx];

  a_r2_blank_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (rd_data == BYTE_BLANK));
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all) |=> (bytes_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/fpw_progseq.sv
module fpw_progseq
  import fpw_pkg::*;
#(
  parameter int BLK_BYTES    = 64,
  parameter int OFS_W        = 6,
  parameter int BLK_W        = 6,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch,
  input  logic                   launch_erase,
  input  logic [BLK_W-1:0]       launch_blk,
  input  logic [7:0]             byte_in,
  output logic [OFS_W-1:0]       byte_idx,
  output logic                   busy,
  output logic                   done,
  output logic                   hold_clr,
  output logic                   fl_valid,
  input  logic                   fl_ready,
  output logic                   fl_erase,
  output logic [BLK_W+OFS_W-1:0] fl_addr,
  output logic [7:0]             fl_data
);
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WRITE_CYCLES - 1);
  localparam logic [OFS_W-1:0] IDX_LAST = OFS_W'(BLK_BYTES - 1);

  logic [TMR_W-1:0] tmr;
  logic [OFS_W-1:0] idx;
  logic             walk_done;
  logic             erase_q;
  logic [BLK_W-1:0] blk_q;
  logic             fin;

  assign fin      = busy && walk_done && (tmr == TMR_LAST);
  assign hold_clr = fin;
  assign byte_idx = idx;
  assign fl_erase = erase_q;
  assign fl_valid = busy && !walk_done && (erase_q || byte_in != BYTE_BLANK);
  assign fl_addr  = erase_q ? {blk_q, {OFS_W{1'b0}}} : {blk_q, idx};
  assign fl_data  = erase_q ? BYTE_BLANK : byte_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      tmr       <= '0;
      idx       <= '0;
      walk_done <= 1'b0;
      erase_q   <= 1'b0;
      blk_q     <= '0;
    end else begin
      done <= fin;
      if (launch && !busy) begin
        busy      <= 1'b1;
        tmr       <= '0;
        idx       <= '0;
        walk_done <= 1'b0;
        erase_q   <= launch_erase;
        blk_q     <= launch_blk;
      end else if (busy) begin
        if (fin) busy <= 1'b0;
        if (tmr != TMR_LAST) tmr <= tmr + TMR_W'(1);
        if (!walk_done) begin
          if (erase_q) begin
            if (fl_ready) walk_done <= 1'b1;
          end else if (byte_in == BYTE_BLANK || fl_ready) begin
            idx <= idx + OFS_W'(1);
            if (idx == IDX_LAST) walk_done <= 1'b1;
          end
        end
      end
    end
  end

  a_r8_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_ready) |=> (fl_valid && $stable(fl_addr) && $stable(fl_data) && $stable(fl_erase)));
  a_r3_no_blank_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_erase) |-> (fl_data != BYTE_BLANK));
  a_r6_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r6_full_timer: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(tmr) == TMR_LAST));
  a_r7_erase_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_ready && fl_erase) |=> !fl_valid);
endmodule

// File: rtl/fpw_ctrl.sv
module fpw_ctrl
  import fpw_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BLK_BYTES    = 64,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_sel,
  input  logic [ADDR_W-1:0] cpu_wdata,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              err_q,
  output logic              stall,
  output logic              done,
  output logic              fl_valid,
  input  logic              fl_ready,
  output logic              fl_erase,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_data
);
  localparam int OFS_W = $clog2(BLK_BYTES);
  localparam int BLK_W = ADDR_W - OFS_W;

  logic             busy;
  logic             acc;
  logic             wr_ptr, wr_latch, wr_ctrl, wr_key, wr_tbl;
  logic             go_wr, launch, hold_clr;
  logic [7:0]       latch_q;
  logic             inc_q;
  logic [OFS_W-1:0] rd_idx;
  logic [7:0]       rd_byte;

  assign acc      = cpu_we && !busy;
  assign wr_ptr   = acc && (cpu_sel == SEL_PTR);
  assign wr_latch = acc && (cpu_sel == SEL_LATCH);
  assign wr_ctrl  = acc && (cpu_sel == SEL_CTRL);
  assign wr_key   = acc && (cpu_sel == SEL_KEY);
  assign wr_tbl   = acc && (cpu_sel == SEL_TBLWR);
  assign go_wr    = wr_ctrl && cpu_wdata[CTRL_GO];
  assign stall    = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      latch_q <= 8'h00;
      inc_q   <= 1'b0;
    end else begin
      if (wr_ptr) ptr_q <= cpu_wdata;
      else if (wr_tbl && inc_q) ptr_q <= ptr_q + ADDR_W'(1);
      if (wr_latch) latch_q <= cpu_wdata[7:0];
      if (wr_ctrl) inc_q <= cpu_wdata[CTRL_INC];
    end
  end

  fpw_keylock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (wr_key),
    .key_val (cpu_wdata[7:0]),
    .go_wr   (go_wr),
    .go_en   (cpu_wdata[CTRL_WREN]),
    .launch  (launch),
    .err     (err_q)
  );

  fpw_holdbuf #(.BLK_BYTES(BLK_BYTES), .OFS_W(OFS_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_tbl),
    .wr_idx  (ptr_q[OFS_W-1:0]),
    .wr_data (latch_q),
    .clr_all (hold_clr),
    .rd_idx  (rd_idx),
    .rd_data (rd_byte)
  );

  fpw_progseq #(
    .BLK_BYTES(BLK_BYTES), .OFS_W(OFS_W), .BLK_W(BLK_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .launch_erase (cpu_wdata[CTRL_ERASE]),
    .launch_blk   (ptr_q[ADDR_W-1:OFS_W]),
    .byte_in      (rd_byte),
    .byte_idx     (rd_idx),
    .busy         (busy),
    .done         (done),
    .hold_clr     (hold_clr),
    .fl_valid     (fl_valid),
    .fl_ready     (fl_ready),
    .fl_erase     (fl_erase),
    .fl_addr      (fl_addr),
    .fl_data      (fl_data)
  );

  a_r9_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(ptr_q));
  a_r9_no_launch_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !launch);
  a_r6_stall_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> stall);
  a_r5_err_stable_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> $stable(err_q));
endmodule

// File: tb/tb_fpw_ctrl.sv
module tb_fpw_ctrl;
  localparam int AW = 8;
  localparam int NB = 64;
  localparam int WC = 80;
  localparam int MEM = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_we = 1'b0;
  logic [2:0] cpu_sel = 3'd0;
  logic [AW-1:0] cpu_wdata = '0;
  logic fl_ready = 1'b1;
  logic [AW-1:0] ptr_q, fl_addr;
  logic err_q, stall, done, fl_valid, fl_erase;
  logic [7:0] fl_data;

  always #2 clk = ~clk;

  fpw_ctrl #(.ADDR_W(AW), .BLK_BYTES(NB), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .ptr_q(ptr_q), .err_q(err_q), .stall(stall), .done(done),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_erase(fl_erase),
    .fl_addr(fl_addr), .fl_data(fl_data)
  );

  int nchk = 0, nerr = 0, cyc = 0, beats = 0, launches = 0;
  bit rnd_ready = 1'b0;
  logic [7:0] flash [MEM];

  int m_hold [NB];
  int exp_flash [MEM];
  int m_ptr, m_latch, m_key, m_cnt, m_idx, m_blk;
  bit m_busy, m_done, m_err, m_inc, m_walk, m_erase;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_valid();
    return m_busy && !m_walk && (m_erase || m_hold[m_idx] != 255);
  endfunction

  initial for (int i = 0; i < MEM; i++) begin flash[i] = 8'hFF; exp_flash[i] = 255; end

  // flash model driven by the DUT stream
  always @(posedge clk) begin
    if (rst_n && fl_valid && fl_ready) begin
      beats++;
      if (fl_erase) for (int i = 0; i < NB; i++) flash[(int'(fl_addr) & ~(NB-1)) + i] = 8'hFF;
      else flash[fl_addr] = flash[fl_addr] & fl_data;
    end
  end

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_inc = 0; m_walk = 0; m_erase = 0;
      m_ptr = 0; m_latch = 0; m_key = 0; m_cnt = 0; m_idx = 0; m_blk = 0;
      for (int i = 0; i < NB; i++) m_hold[i] = 255;
    end else begin
      bit fin;
      fin = m_busy && m_walk && (m_cnt >= WC - 1);
      if (m_busy) begin
        if (m_valid() && fl_ready) begin
          if (m_erase) for (int i = 0; i < NB; i++) exp_flash[m_blk*NB + i] = 255;
          else exp_flash[m_blk*NB + m_idx] = exp_flash[m_blk*NB + m_idx] & m_hold[m_idx];
        end
        if (!m_walk) begin
          if (m_erase) begin
            if (fl_ready) m_walk = 1;
          end else if (m_hold[m_idx] == 255 || fl_ready) begin
            if (m_idx == NB - 1) m_walk = 1;
            m_idx = (m_idx + 1) % NB;
          end
        end
        m_cnt++;
        if (fin) begin
          m_busy = 0;
          for (int i = 0; i < NB; i++) m_hold[i] = 255;
        end
      end else if (cpu_we) begin
        case (int'(cpu_sel))
          0: m_ptr = int'(cpu_wdata);
          1: m_latch = int'(cpu_wdata);
          2: begin
            m_inc = cpu_wdata[3];
            if (cpu_wdata[1]) begin
              if (cpu_wdata[0] && m_key == 2) begin
                m_busy = 1; m_cnt = 0; m_idx = 0; m_walk = 0;
                m_erase = cpu_wdata[2]; m_blk = m_ptr / NB; m_err = 0;
              end else m_err = 1;
              m_key = 0;
            end
          end
          3: begin
            if (m_key == 0 && cpu_wdata == 8'h55) m_key = 1;
            else if (m_key == 1 && cpu_wdata == 8'hAA) m_key = 2;
            else begin m_key = 0; m_err = 1; end
          end
          4: begin
            m_hold[m_ptr % NB] = m_latch;
            if (m_inc) m_ptr = (m_ptr + 1) % MEM;
          end
          default: ;
        endcase
      end
      m_done = fin;
    end
  end

  // per-cycle comparison away from the active edge
  bit prev_stall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(stall == m_busy, "R6 stall", stall, m_busy);
      chk(done == m_done, "R6 done", done, m_done);
      chk(err_q == m_err, "R5 err", err_q, m_err);
      chk(int'(ptr_q) == m_ptr, "R1/R9 ptr", ptr_q, m_ptr);
      chk(fl_valid == m_valid(), "R3/R8 valid", fl_valid, m_valid());
      if (m_valid()) begin
        chk(fl_erase == m_erase, "R7 erase", fl_erase, m_erase);
        chk(int'(fl_addr) == (m_erase ? m_blk*NB : m_blk*NB + m_idx), "R3/R7 addr", fl_addr,
            m_erase ? m_blk*NB : m_blk*NB + m_idx);
        chk(int'(fl_data) == (m_erase ? 255 : m_hold[m_idx]), "R3 data", fl_data,
            m_erase ? 255 : m_hold[m_idx]);
      end
      if (stall && !prev_stall) launches++;
      prev_stall = stall;
      if (rnd_ready) fl_ready <= 1'($urandom_range(0, 1));
      else fl_ready <= 1'b1;
    end
  end

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    cpu_we = 1'b1; cpu_sel = 3'(sel); cpu_wdata = AW'(data);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic unlock();
    wr(3, 8'h55); wr(3, 8'hAA);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic flash_cmp(input string tag);
    int bad = 0;
    for (int i = 0; i < MEM; i++) if (int'(flash[i]) != exp_flash[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nerr++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int l0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !done && !err_q && ptr_q == 0 && !fl_valid, "R2 reset state", stall, 0);

    // R2: empty holding buffer programs nothing
    wr(2, 8'h08);
    beats = 0; l0 = launches;
    unlock(); wr(2, 8'h0B); wait_done();
    chk(beats == 0, "R2 no beats from blank buffer", beats, 0);
    chk(launches == l0 + 1, "R4 launch with key pair", launches, l0 + 1);

    // R1/R3: partial load with an FF byte in the middle
    wr(0, 8'h40);
    for (int i = 0; i < 10; i++) begin
      wr(1, (i == 4) ? 8'hFF : (i * 7 + 1)); wr(4, 0);
    end
    chk(ptr_q == 8'h4A, "R1 autoinc", ptr_q, 8'h4A);
    beats = 0;
    unlock(); wr(2, 8'h0B); wait_done();
    chk(beats == 9, "R3 FF byte skipped", beats, 9);
    flash_cmp("R3 flash after program");

    // R3: AND semantics over programmed bytes
    wr(0, 8'h41); wr(1, 8'hF0); wr(4, 0); wr(1, 8'hFE); wr(4, 0);
    unlock(); wr(2, 8'h0B); wait_done();
    chk(flash[8'h41] == (8'h08 & 8'hF0), "R3 AND result", flash[8'h41], 8'h08 & 8'hF0);
    flash_cmp("R3 flash after overwrite");

    // R5: bad key orders and bad starts
    l0 = launches;
    wr(3, 8'h12);
    chk(err_q == 1'b1, "R5 wrong first key", err_q, 1);
    wr(3, 8'h55); wr(3, 8'h33); wr(2, 8'h0B);
    unlock(); wr(3, 8'hAA); wr(2, 8'h0B);
    unlock(); wr(2, 8'h0A);
    chk(launches == l0, "R4 no launch without proper unlock", launches, l0);
    unlock(); wr(2, 8'h0B);
    @(negedge clk);
    chk(err_q == 1'b0, "R5 err cleared by launch", err_q, 0);
    wait_done();

    // R10: start again without a new key pair
    l0 = launches;
    wr(2, 8'h0B);
    chk(launches == l0 && err_q, "R10 start needs fresh keys", launches, l0);

    // R7: erase block 1
    wr(0, 8'h47);
    beats = 0;
    unlock(); wr(2, 8'h0F); wait_done();
    chk(beats == 1, "R7 single erase beat", beats, 1);
    chk(flash[8'h40] == 8'hFF && flash[8'h41] == 8'hFF, "R7 block blank", flash[8'h41], 8'hFF);
    flash_cmp("R7 flash after erase");

    // R8/R9: full block under random back-pressure, writes during stall
    wr(0, 8'h80);
    for (int i = 0; i < NB; i++) begin wr(1, ((i * 13) ^ 8'h5A) & 8'hFE); wr(4, 0); end
    chk(ptr_q == 8'hC0, "R1 pointer after full block", ptr_q, 8'hC0);
    wr(0, 8'h80);
    rnd_ready = 1'b1;
    beats = 0; l0 = launches;
    unlock(); wr(2, 8'h0B);
    wr(0, 8'h11); wr(1, 8'h00); wr(4, 0); wr(3, 8'h55); wr(3, 8'hAA); wr(2, 8'h0B);
    wait_done();
    rnd_ready = 1'b0;
    chk(beats == NB, "R8 all beats delivered", beats, NB);
    chk(launches == l0 + 1 && ptr_q == 8'h80, "R9 stall writes ignored", ptr_q, 8'h80);
    flash_cmp("R3/R8 flash after full block");

    // R2: buffer blank after completion
    beats = 0;
    unlock(); wr(2, 8'h0B); wait_done();
    chk(beats == 0, "R2 cleared after long write", beats, 0);

    // R1: pointer wrap
    wr(0, 8'hFF); wr(1, 8'h3C); wr(4, 0);
    chk(ptr_q == 8'h00, "R1 pointer wraps", ptr_q, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule